// File: doc/BRIEF.md
# Stack-Register Reverse-Divide Unit

This block carries out reverse division against an eight-entry register stack. The dividend is the source operand and the divisor is the current stack destination. The quotient goes back into that destination. A two-byte opcode selects the operands. A register form picks two stack entries. A memory form takes its dividend from a value that has already been fetched. That value is read as an internal real, or as a small integer that the block scales into the internal format. Some opcodes also retire the top of the stack once the result is written.

The stack itself is held outside the block. At start, the unit samples the stack contents, the per-entry empty tags and the top pointer. It then runs a restoring divider that yields one quotient bit per cycle. In the single cycle that raises `done`, it reports the write-back and pop requests, which the surrounding logic applies. Each value is 18 bits wide: bit 17 is the sign, bit 16 is the infinity flag, and bits 15:0 hold an unsigned magnitude with 8 fraction bits. A divide-by-zero mask input chooses between storing a signed infinity and raising a quiet exception flag.

Top module: `revdiv_unit`

## Requirements
- R1: Memory form: the first byte is D8, DC, DA or DE, and the second byte has bits 7:6 not equal to 11 and bits 5:3 equal to 7. The dividend is `memOperand`, the divisor and destination are ST(0), and no pop occurs. For D8 and DC, all 18 bits of `memOperand` are taken as an internal value.
- R2: For DA and DE in memory form, the low 8 bits of `memOperand` form a two's-complement integer n. The dividend becomes sign(n) with magnitude abs(n)*256 and the infinity flag clear. The upper bits of `memOperand` are ignored.
- R3: D8 followed by F8+i divides ST(i) by ST(0) and writes ST(0), with no pop.
- R4: DC followed by F0+i divides ST(0) by ST(i) and writes ST(i), with no pop.
- R5: DE followed by F0+i, including DE F1, divides ST(0) by ST(i) and writes ST(i). It then pops: `popIdx` is the physical index of the old ST(0), and `newTop` is TOP+1 modulo 8.
- R6: ST(k) is physical entry (TOP+k) mod 8, and every index is resolved with the TOP value sampled at start.
- R7: A finite nonzero divisor gives a magnitude of floor(a*256/b), saturating at 0xFFFF. The result sign is the XOR of the operand signs and the infinity flag is clear.
- R8: If the divisor is zero (magnitude 0, infinity clear) and `zdMask`=1, the block writes an infinity whose sign is the XOR of the operand signs. The pop follows the opcode.
- R9: If the divisor is zero and `zdMask`=0, `zeroDiv` rises with `done`, and there is no write and no pop.
- R10: An unrecognised opcode, or a divisor entry whose tag is empty, raises `invalid` with `done`, and there is no write and no pop.
- R11: An infinite divisor with a finite dividend writes a signed zero. An infinite dividend with a finite divisor writes a signed infinity. Two infinite operands are treated as invalid.
- R12: A start that is sampled while idle leads to `done` for exactly one cycle, and everything reported in that cycle belongs to the accepted instruction. The special outcomes of R8 to R11 raise `done` in the first cycle after the start edge, with `busy` low. A division holds `busy` high for 24 cycles, and `done` follows in the 25th. While busy or done, `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| opByte0 | input | 8 | First opcode byte |
| opByte1 | input | 8 | Second opcode byte (register selector or reg field) |
| memOperand | input | 18 | Fetched memory dividend |
| stackFlat | input | 144 | Physical entry p at bits p*18 +: 18 |
| emptyTags | input | 8 | Empty tag per physical entry |
| topIn | input | 3 | Current stack top pointer |
| zdMask | input | 1 | Divide-by-zero mask |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| wrEn | output | 1 | Write-back request |
| wrIdx | output | 3 | Physical write-back index |
| wrVal | output | 18 | Value to write |
| popEn | output | 1 | Pop request |
| popIdx | output | 3 | Physical entry to tag empty |
| newTop | output | 3 | Top pointer after the pop |
| invalid | output | 1 | Invalid-operation flag |
| zeroDiv | output | 1 | Unmasked divide-by-zero flag |

## Verification
Outcomes that need no division (invalid, zero divisor, infinite operand) are due in the first cycle after the edge that samples `start`. A quotient is due 25 cycles after that edge. The bench keeps a behavioural countdown for each accepted instruction and compares `busy` and `done` on every falling edge. In the single cycle where `done` is expected, it also compares every result field. In all other cycles it requires that no write, pop or flag is raised.

// File: rtl/revdiv_pkg.sv
package revdiv_pkg;
  typedef enum logic [1:0] {
    RES_QUOT = 2'd0,
    RES_INF  = 2'd1,
    RES_ZERO = 2'd2
  } resKind_e;

  typedef struct packed {
    logic     load;
    logic     step;
    resKind_e kind;
  } dpStrobe_t;
endpackage

// File: rtl/revdiv_ctrl.sv
module revdiv_ctrl
  import revdiv_pkg::*;
#(
  parameter int QBITS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opByte0,
  input  logic [7:0] opByte1,
  input  logic [7:0] emptyTags,
  input  logic [2:0] topIn,
  input  logic       zdMask,
  input  logic       divZero,
  input  logic       divInf,
  input  logic       dvdInf,
  output dpStrobe_t  stb,
  output logic       dvdFromMem,
  output logic       dvdIsInt,
  output logic [2:0] dvdIdx,
  output logic [2:0] divIdx,
  output logic       busy,
  output logic       done,
  output logic       wrEn,
  output logic [2:0] wrIdx,
  output logic       popEn,
  output logic [2:0] popIdx,
  output logic [2:0] newTop,
  output logic       invalid,
  output logic       zeroDiv
);
  localparam int CW = $clog2(QBITS);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_DONE} state_e;

  state_e   state;
  logic [CW-1:0] cnt;
  resKind_e rKind;
  logic     rWr, rPop, rInv, rZd;
  logic [2:0] rTop, rDst;

  logic opValid, doPop, memForm, isMemOp;
  logic [2:0] dvdK, divK, dstK;
  logic accept;

  // Opcode decode: operand roles as stack offsets
  always_comb begin
    isMemOp = (opByte0 == 8'hD8) || (opByte0 == 8'hDC) ||
              (opByte0 == 8'hDA) || (opByte0 == 8'hDE);
    memForm = isMemOp && (opByte1[7:6] != 2'b11) && (opByte1[5:3] == 3'd7);
    opValid = memForm;
    doPop   = 1'b0;
    dvdK    = 3'd0;
    divK    = 3'd0;
    dstK    = 3'd0;
    if (opByte1[7:6] == 2'b11) begin
      if (opByte0 == 8'hD8 && opByte1[7:3] == 5'b11111) begin
        opValid = 1'b1;
        dvdK    = opByte1[2:0];
      end else if ((opByte0 == 8'hDC || opByte0 == 8'hDE) && opByte1[7:3] == 5'b11110) begin
        opValid = 1'b1;
        divK    = opByte1[2:0];
        dstK    = opByte1[2:0];
        doPop   = (opByte0 == 8'hDE);
      end
    end
    dvdFromMem = memForm;
    dvdIsInt   = memForm && (opByte0 == 8'hDA || opByte0 == 8'hDE);
    dvdIdx     = topIn + dvdK;
    divIdx     = topIn + divK;
  end

  assign accept = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      rKind <= RES_QUOT;
      rWr   <= 1'b0;
      rPop  <= 1'b0;
      rInv  <= 1'b0;
      rZd   <= 1'b0;
      rTop  <= 3'd0;
      rDst  <= 3'd0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          rTop  <= topIn;
          rDst  <= topIn + dstK;
          rWr   <= 1'b0;
          rPop  <= 1'b0;
          rInv  <= 1'b0;
          rZd   <= 1'b0;
          rKind <= RES_QUOT;
          cnt   <= '0;
          state <= S_DONE;
          if (!opValid || emptyTags[divIdx]) begin
            rInv <= 1'b1;
          end else if (divZero) begin
            if (zdMask) begin
              rWr   <= 1'b1;
              rPop  <= doPop;
              rKind <= RES_INF;
            end else begin
              rZd <= 1'b1;
            end
          end else if (divInf) begin
            if (dvdInf) begin
              rInv <= 1'b1;
            end else begin
              rWr   <= 1'b1;
              rPop  <= doPop;
              rKind <= RES_ZERO;
            end
          end else if (dvdInf) begin
            rWr   <= 1'b1;
            rPop  <= doPop;
            rKind <= RES_INF;
          end else begin
            rWr   <= 1'b1;
            rPop  <= doPop;
            state <= S_DIV;
          end
        end
        S_DIV: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(QBITS - 1)) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stb.load = accept;
  assign stb.step = (state == S_DIV);
  assign stb.kind = rKind;

  assign busy    = (state == S_DIV);
  assign done    = (state == S_DONE);
  assign wrEn    = done && rWr;
  assign wrIdx   = rDst;
  assign popEn   = done && rPop;
  assign popIdx  = rTop;
  assign newTop  = rTop + 3'd1;
  assign invalid = done && rInv;
  assign zeroDiv = done && rZd;
endmodule

// File: rtl/revdiv_dpath.sv
module revdiv_dpath
  import revdiv_pkg::*;
#(
  parameter int MW   = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [MW+1:0]       memOperand,
  input  logic [8*(MW+2)-1:0] stackFlat,
  input  logic                dvdFromMem,
  input  logic                dvdIsInt,
  input  logic [2:0]          dvdIdx,
  input  logic [2:0]          divIdx,
  output logic                divZero,
  output logic                divInf,
  output logic                dvdInf,
  output logic [MW+1:0]       wrVal
);
  localparam int VW    = MW + 2;
  localparam int QBITS = MW + FRAC;
  localparam int INTW  = MW - FRAC;

  logic [VW-1:0]   divRaw, dvdSel, intVal;
  logic [INTW-1:0] intRaw, intAbs;
  logic [MW:0]     trial, diff;
  logic            sgn, sat;
  logic [MW-1:0]   divMag, rem;
  logic [QBITS-1:0] sh, quo;

  always_comb begin
    intRaw = memOperand[INTW-1:0];
    intAbs = intRaw[INTW-1] ? (~intRaw + 1'b1) : intRaw;
    intVal = {intRaw[INTW-1], 1'b0, intAbs, {FRAC{1'b0}}};
    divRaw = stackFlat[divIdx*VW +: VW];
    if (dvdFromMem) dvdSel = dvdIsInt ? intVal : memOperand;
    else            dvdSel = stackFlat[dvdIdx*VW +: VW];
    divInf  = divRaw[VW-2];
    divZero = !divRaw[VW-2] && (divRaw[MW-1:0] == '0);
    dvdInf  = dvdSel[VW-2];
  end

  // Restoring divider, one quotient bit per step
  assign trial = {rem, sh[QBITS-1]};
  assign diff  = trial - {1'b0, divMag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sgn    <= 1'b0;
      divMag <= '0;
      rem    <= '0;
      sh     <= '0;
      quo    <= '0;
    end else if (stb.load) begin
      sgn    <= dvdSel[VW-1] ^ divRaw[VW-1];
      divMag <= divRaw[MW-1:0];
      rem    <= '0;
      sh     <= {dvdSel[MW-1:0], {FRAC{1'b0}}};
      quo    <= '0;
    end else if (stb.step) begin
      sh <= {sh[QBITS-2:0], 1'b0};
      if (!diff[MW]) begin
        rem <= diff[MW-1:0];
        quo <= {quo[QBITS-2:0], 1'b1};
      end else begin
        rem <= trial[MW-1:0];
        quo <= {quo[QBITS-2:0], 1'b0};
      end
    end
  end

  assign sat = |quo[QBITS-1:MW];

  always_comb begin
    case (stb.kind)
      RES_INF:  wrVal = {sgn, 1'b1, {MW{1'b0}}};
      RES_ZERO: wrVal = {sgn, 1'b0, {MW{1'b0}}};
      default:  wrVal = {sgn, 1'b0, sat ? {MW{1'b1}} : quo[MW-1:0]};
    endcase
  end
endmodule

// File: rtl/revdiv_unit.sv
module revdiv_unit
  import revdiv_pkg::*;
#(
  parameter int MW   = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [7:0]          opByte0,
  input  logic [7:0]          opByte1,
  input  logic [MW+1:0]       memOperand,
  input  logic [8*(MW+2)-1:0] stackFlat,
  input  logic [7:0]          emptyTags,
  input  logic [2:0]          topIn,
  input  logic                zdMask,
  output logic                busy,
  output logic                done,
  output logic                wrEn,
  output logic [2:0]          wrIdx,
  output logic [MW+1:0]       wrVal,
  output logic                popEn,
  output logic [2:0]          popIdx,
  output logic [2:0]          newTop,
  output logic                invalid,
  output logic                zeroDiv
);
  localparam int QBITS = MW + FRAC;

  dpStrobe_t  stb;
  logic       dvdFromMem, dvdIsInt, divZero, divInf, dvdInf;
  logic [2:0] dvdIdx, divIdx;

  revdiv_ctrl #(.QBITS(QBITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opByte0(opByte0), .opByte1(opByte1),
    .emptyTags(emptyTags), .topIn(topIn), .zdMask(zdMask),
    .divZero(divZero), .divInf(divInf), .dvdInf(dvdInf),
    .stb(stb), .dvdFromMem(dvdFromMem), .dvdIsInt(dvdIsInt),
    .dvdIdx(dvdIdx), .divIdx(divIdx),
    .busy(busy), .done(done), .wrEn(wrEn), .wrIdx(wrIdx),
    .popEn(popEn), .popIdx(popIdx), .newTop(newTop),
    .invalid(invalid), .zeroDiv(zeroDiv)
  );

  revdiv_dpath #(.MW(MW), .FRAC(FRAC)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .memOperand(memOperand),
    .stackFlat(stackFlat), .dvdFromMem(dvdFromMem), .dvdIsInt(dvdIsInt),
    .dvdIdx(dvdIdx), .divIdx(divIdx),
    .divZero(divZero), .divInf(divInf), .dvdInf(dvdInf), .wrVal(wrVal)
  );
endmodule

// File: rtl/revdiv_chk.sv
module revdiv_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic wrEn,
  input logic popEn,
  input logic invalid,
  input logic zeroDiv
);
  // R12
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> (busy || done));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R9
  zd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroDiv |-> (!wrEn && !popEn));

  // R10
  inv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalid |-> (!wrEn && !popEn && !zeroDiv));
endmodule

bind revdiv_unit revdiv_chk i_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .wrEn(wrEn), .popEn(popEn), .invalid(invalid), .zeroDiv(zeroDiv)
);

// File: tb/test_revdiv_unit.sv
module test_revdiv_unit;
  localparam int MW = 16;
  localparam int FRAC = 8;
  localparam int VW = MW + 2;
  localparam int NQ = MW + FRAC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] opByte0 = 8'h00, opByte1 = 8'h00;
  logic [VW-1:0] memOperand = '0;
  logic [8*VW-1:0] stackFlat;
  logic [7:0] emptyTags;
  logic [2:0] topIn;
  logic zdMask = 1'b0;
  logic busy, done, wrEn, popEn, invalid, zeroDiv;
  logic [2:0] wrIdx, popIdx, newTop;
  logic [VW-1:0] wrVal;

  logic [VW-1:0] stk [8];
  logic emp [8];
  int top = 0;

  int nCmp = 0, nBad = 0;
  string curTag = "R12", mTag = "R12";

  int mWait = 0;
  bit mDone = 1'b0;
  bit eWr, ePop, eInv, eZd;
  int eWrIdx, ePopIdx, eNewTop;
  logic [VW-1:0] eWrVal;

  always #10 clk = ~clk;

  always_comb begin
    for (int p = 0; p < 8; p++) begin
      stackFlat[p*VW +: VW] = stk[p];
      emptyTags[p] = emp[p];
    end
    topIn = top[2:0];
  end

  revdiv_unit #(.MW(MW), .FRAC(FRAC)) i_revdiv_unit (
    .clk(clk), .rstN(rstN), .start(start), .opByte0(opByte0), .opByte1(opByte1),
    .memOperand(memOperand), .stackFlat(stackFlat), .emptyTags(emptyTags),
    .topIn(topIn), .zdMask(zdMask), .busy(busy), .done(done), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrVal(wrVal), .popEn(popEn), .popIdx(popIdx),
    .newTop(newTop), .invalid(invalid), .zeroDiv(zeroDiv)
  );

  function automatic logic [VW-1:0] mkv(bit s, int m);
    return {s, 1'b0, m[15:0]};
  endfunction

  function automatic logic [VW-1:0] mkInf(bit s);
    return {s, 1'b1, 16'h0000};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: predicts the outcome of an accepted instruction
  task automatic predict();
    bit memF, valid, pop, isInt, sx;
    int dvdK, divK, dstK, divP, i;
    logic [VW-1:0] a, b;
    longint q;
    memF = (opByte1[7:6] != 2'b11) && (opByte1[5:3] == 3'd7) &&
           (opByte0 == 8'hD8 || opByte0 == 8'hDC || opByte0 == 8'hDA || opByte0 == 8'hDE);
    isInt = memF && (opByte0 == 8'hDA || opByte0 == 8'hDE);
    i = int'(opByte1[2:0]);
    valid = memF; pop = 0; dvdK = 0; divK = 0; dstK = 0;
    if (!memF && opByte0 == 8'hD8 && opByte1 >= 8'hF8) begin valid = 1; dvdK = i; end
    if (!memF && (opByte0 == 8'hDC || opByte0 == 8'hDE) && opByte1 >= 8'hF0 && opByte1 <= 8'hF7) begin
      valid = 1; divK = i; dstK = i; pop = (opByte0 == 8'hDE);
    end
    if (memF) begin
      if (isInt) begin
        int n;
        n = int'($signed(memOperand[7:0]));
        a = mkv(n < 0, (n < 0 ? -n : n) * 256);
      end else a = memOperand;
    end else a = stk[(top + dvdK) % 8];
    divP = (top + divK) % 8;
    b = stk[divP];
    sx = a[17] ^ b[17];
    eWr = 0; ePop = 0; eInv = 0; eZd = 0; eWrVal = '0;
    eWrIdx = (top + dstK) % 8; ePopIdx = top; eNewTop = (top + 1) % 8;
    mTag = curTag;
    mWait = 0; mDone = 1;
    if (!valid || emp[divP]) eInv = 1;
    else if (!b[16] && b[15:0] == 0) begin
      if (zdMask) begin eWr = 1; ePop = pop; eWrVal = mkInf(sx); end
      else eZd = 1;
    end else if (b[16]) begin
      if (a[16]) eInv = 1;
      else begin eWr = 1; ePop = pop; eWrVal = mkv(sx, 0); end
    end else if (a[16]) begin
      eWr = 1; ePop = pop; eWrVal = mkInf(sx);
    end else begin
      q = (longint'(a[15:0]) * 256) / longint'(b[15:0]);
      if (q > 65535) q = 65535;
      eWr = 1; ePop = pop; eWrVal = mkv(sx, int'(q));
      mWait = NQ; mDone = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mWait = 0; mDone = 0;
    end else if (mDone) begin
      if (eWr) begin stk[eWrIdx] = eWrVal; emp[eWrIdx] = 0; end
      if (ePop) begin emp[top] = 1; top = (top + 1) % 8; end
      mDone = 0;
    end else if (mWait > 0) begin
      mWait--;
      if (mWait == 0) mDone = 1;
    end else if (start) begin
      predict();
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(busy == (mWait > 0), "R12", "busy", busy, mWait > 0);
      chk(done == mDone, "R12", "done", done, mDone);
      if (mDone) begin
        chk(wrEn == eWr, mTag, "wrEn", wrEn, eWr);
        chk(popEn == ePop, mTag, "popEn", popEn, ePop);
        chk(invalid == eInv, mTag, "invalid", invalid, eInv);
        chk(zeroDiv == eZd, mTag, "zeroDiv", zeroDiv, eZd);
        if (eWr) begin
          chk(wrIdx == eWrIdx[2:0], mTag, "wrIdx", wrIdx, eWrIdx);
          chk(wrVal == eWrVal, mTag, "wrVal", wrVal, eWrVal);
        end
        if (ePop) begin
          chk(popIdx == ePopIdx[2:0], mTag, "popIdx", popIdx, ePopIdx);
          chk(newTop == eNewTop[2:0], mTag, "newTop", newTop, eNewTop);
        end
      end else begin
        chk(!(wrEn || popEn || invalid || zeroDiv), "R12", "quiet outputs",
            {wrEn, popEn, invalid, zeroDiv}, 0);
      end
    end
  end

  task automatic doOp(string tag, logic [7:0] b0, logic [7:0] b1, logic [VW-1:0] mem, bit mask);
    @(negedge clk);
    curTag = tag; opByte0 = b0; opByte1 = b1; memOperand = mem; zdMask = mask;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (mWait > 0 || mDone) @(negedge clk);
  endtask

  task automatic fillStack();
    for (int p = 0; p < 8; p++) begin
      stk[p] = mkv(p % 2, (p + 1) * 256 + p * 16);
      emp[p] = 0;
    end
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R12 watchdog expired actual=1 expected=0");
    finish();
  end

  initial begin
    fillStack();
    top = 5;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R12", "reset state", {busy, done}, 0);
    rstN = 1'b1;

    doOp("R3", 8'hD8, 8'hFA, '0, 1);            // ST2/ST0 -> ST0
    doOp("R4", 8'hDC, 8'hF3, '0, 1);            // ST0/ST3, ST3 wraps to phys 0
    doOp("R6", 8'hD8, 8'hFF, '0, 1);            // ST7 wraps to phys 4
    doOp("R1", 8'hD8, 8'h38, mkv(1, 10 * 256), 1);
    doOp("R1", 8'hDC, 8'h7E, mkv(0, 1000), 1);
    doOp("R2", 8'hDA, 8'h3F, 18'h2AA80, 1);      // -128
    doOp("R2", 8'hDE, 8'hBF, 18'h15505, 1);      // +5

    // R7: saturation and small quotient
    stk[(top + 1) % 8] = mkv(0, 16'hFF00);
    stk[top] = mkv(1, 1);
    doOp("R7", 8'hD8, 8'hF9, '0, 1);
    stk[(top + 1) % 8] = mkv(1, 3);
    stk[top] = mkv(1, 16'hF000);
    doOp("R7", 8'hD8, 8'hF9, '0, 1);

    // R8: masked zero divisor with pop
    stk[(top + 2) % 8] = mkv(1, 0);
    doOp("R8", 8'hDE, 8'hF2, '0, 1);
    // R9: unmasked zero divisor, nothing changes
    stk[(top + 3) % 8] = mkv(0, 0);
    doOp("R9", 8'hDE, 8'hF3, '0, 0);
    doOp("R9", 8'hDC, 8'hF3, '0, 0);

    // R10: bad opcodes and empty divisor (entry popped above)
    doOp("R10", 8'hD9, 8'hF8, '0, 1);
    doOp("R10", 8'hDA, 8'hF9, '0, 1);
    doOp("R10", 8'hD8, 8'hF0, '0, 1);
    doOp("R10", 8'hDC, 8'hF7, '0, 1);

    // R11: infinite operands
    fillStack();
    stk[top] = mkInf(1);
    doOp("R11", 8'hD8, 8'hF9, '0, 1);
    doOp("R11", 8'hD8, 8'h38, mkInf(1), 1);
    stk[top] = mkv(0, 512);
    doOp("R11", 8'hD8, 8'h38, mkInf(0), 1);

    // R5: pops, wrapping TOP from 7 to 0
    fillStack();
    top = 6;
    doOp("R5", 8'hDE, 8'hF1, '0, 1);
    doOp("R5", 8'hDE, 8'hF1, '0, 1);
    doOp("R5", 8'hDE, 8'hF2, '0, 1);

    // R12: start held during a division is ignored
    fillStack();
    @(negedge clk);
    curTag = "R12"; opByte0 = 8'hD8; opByte1 = 8'hF9; start = 1'b1;
    @(negedge clk);
    opByte0 = 8'hDE; opByte1 = 8'hF1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (mWait > 0 || mDone) @(negedge clk);
    repeat (2) @(negedge clk);
    finish();
  end
endmodule